// File: doc/BRIEF.md
# Platform reset sequencer

This block drives the active-low reset line that clears every downstream device on the platform. The line is held low from power-up until two power-good inputs are both high, one for core power and one for the voltage regulator, and then for a minimum hold time after that. Both power-good inputs are asynchronous. Each passes through a two-flop synchronizer before the block uses it.

Three other events can pull the line low again. A one-cycle software hard-reset request starts a timed reset pulse. A debounced external system-reset pin also starts a pulse, but first it waits, up to a bounded time, for a side-band management bus to go idle. A drop on core power-good pulls the line low at once. Only a drop that lasts several slow real-time-clock strobes restarts the full power-up sequence.

All millisecond timings are counted in strobes of a 1 kHz tick input. The count limits are parameters:
- the hold time defaults to two strobes, which gives at least 1 ms whatever the strobe phase;
- the bus wait defaults to 26 strobes, which lands inside the 23 to 27 ms window.

A status output reports whether the most recent external reset was forced by the wait timing out.

Top module: `plat_rst_seq`

## Requirements
- R1: `plat_rst_n` is low while `rst_n` is low, while `vrm_pg_a` is low, and until both power-good inputs have been seen high. One clock after the synchronized `vrm_pg_a` is low, `plat_rst_n` is low.
- R2: Once both power-good inputs are high, `plat_rst_n` stays low until HOLD_TICKS `tick_ms` strobes have been counted. It then goes high.
- R3: A one-cycle high on `sw_hard_req` while the platform runs drives `plat_rst_n` low at the next clock edge. The line then stays low for HOLD_TICKS strobes.
- R4: A `sw_hard_req` that arrives while a reset pulse or a power-up hold is in progress restarts the hold count from zero.
- R5: A low on `core_pg_a` drives `plat_rst_n` low within two clock edges, which is the synchronizer delay.
- R6: A `core_pg_a` low that spans fewer than RTC_FILT `rtc_tick` strobes is filtered: when the input returns high, `plat_rst_n` goes high again within three clocks, with no hold time. A low that spans RTC_FILT strobes restarts the sequence of R2.
- R7: `ext_rst_req_n` is an active-low request. It is acted on only after it has stayed low for DEB_TICKS `tick_ms` strobes. Shorter lows have no effect on `plat_rst_n`.
- R8: An accepted external request with `mgmt_bus_idle` high (1 = idle) starts a reset pulse within two clocks. The pulse is held for HOLD_TICKS strobes.
- R9: When the bus is busy at acceptance, `plat_rst_n` stays high while the block waits. The pulse starts one clock after `mgmt_bus_idle` rises, or after WAIT_TICKS strobes if the bus stays busy.
- R10: `ext_forced` goes to 1 when an external reset is forced by the wait timing out. It goes back to 0 when a later external reset proceeds because the bus was idle, or on `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset of the sequencer's own logic |
| tick_ms | input | 1 | 1 kHz strobe, one clock wide |
| rtc_tick | input | 1 | Slow real-time-clock strobe, one clock wide |
| core_pg_a | input | 1 | Core power-good, asynchronous |
| vrm_pg_a | input | 1 | Regulator power-good, asynchronous |
| sw_hard_req | input | 1 | Software hard-reset request, one-cycle pulse |
| ext_rst_req_n | input | 1 | External system-reset pin, active low, not yet debounced |
| mgmt_bus_idle | input | 1 | Management bus is idle when 1 |
| plat_rst_n | output | 1 | Platform reset, active low |
| ext_forced | output | 1 | Last external reset was forced by the wait timing out |

## Verification
The power-good inputs are tried in several patterns:
- Raised one at a time, which separates gating on both inputs from gating on either one.
- Dropped briefly and then for long, which separates the filtered dip from a full restart with a hold.

The external pin is tried in four ways:
- A glitch shorter than the debounce time.
- A request with the bus idle.
- A request with the bus busy throughout, which separates waiting from the timeout.
- A request with the bus going idle part-way, which separates the early start from the timeout and drives the status flag both ways.

A software request repeated in mid-pulse separates a restarted hold count from a continued one.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [2:0] {
    ST_PWR_WAIT  = 3'd0,
    ST_HOLD      = 3'd1,
    ST_RUN       = 3'd2,
    ST_SW_PULSE  = 3'd3,
    ST_BUS_WAIT  = 3'd4,
    ST_EXT_PULSE = 3'd5
  } prs_state_e;
endpackage

// File: rtl/prs_sync2.sv
module prs_sync2 #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_a[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/prs_debounce.sv
module prs_debounce #(
  parameter int DEB_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic filt
);
  localparam int DW = $clog2(DEB_TICKS + 1);
  localparam logic [DW-1:0] LAST = DW'(DEB_TICKS - 1);

  logic          raw_d;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_d <= 1'b1;
      filt  <= 1'b1;
      cnt   <= '0;
    end else begin
      raw_d <= raw;
      if (raw != raw_d || raw == filt) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          filt <= raw;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_DEB_FOLLOWS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> ($past(raw) == filt) && $past(tick)); // R7
endmodule

// File: rtl/prs_pg_filter.sv
module prs_pg_filter #(
  parameter int RTC_FILT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rtc_tick,
  input  logic pg,
  output logic long_low
);
  localparam int FW = $clog2(RTC_FILT + 1);
  localparam logic [FW-1:0] LIM = FW'(RTC_FILT);

  logic [FW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= LIM;
    end else if (pg) begin
      cnt <= '0;
    end else if (rtc_tick && cnt != LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign long_low = (cnt == LIM);

  AST_FILTER_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_low) |-> !$past(pg) && $past(rtc_tick)); // R6
endmodule

// File: rtl/prs_tick_cnt.sv
module prs_tick_cnt #(
  parameter int MAXV = 26,
  localparam int CW = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP = CW'(MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (tick && cnt != TOP) cnt <= cnt + 1'b1;
  end

  AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP); // R2
endmodule

// File: rtl/plat_rst_seq.sv
module plat_rst_seq
  import prs_pkg::*;
#(
  parameter int HOLD_TICKS = 2,
  parameter int WAIT_TICKS = 26,
  parameter int DEB_TICKS  = 16,
  parameter int RTC_FILT   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic rtc_tick,
  input  logic core_pg_a,
  input  logic vrm_pg_a,
  input  logic sw_hard_req,
  input  logic ext_rst_req_n,
  input  logic mgmt_bus_idle,
  output logic plat_rst_n,
  output logic ext_forced
);
  localparam int CNT_MAX = (HOLD_TICKS > WAIT_TICKS) ? HOLD_TICKS : WAIT_TICKS;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD_TICKS);
  localparam logic [CW-1:0] WAIT_C = CW'(WAIT_TICKS);

  logic [2:0] sync_q;
  logic core_s, vrm_s, ext_s;

  prs_sync2 #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_a({ext_rst_req_n, vrm_pg_a, core_pg_a}),
    .q(sync_q)
  );
  assign core_s = sync_q[0];
  assign vrm_s  = sync_q[1];
  assign ext_s  = sync_q[2];

  logic ext_filt, ext_filt_d, core_long;

  prs_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms), .raw(ext_s), .filt(ext_filt)
  );

  prs_pg_filter #(.RTC_FILT(RTC_FILT)) u_pgf (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .pg(core_s), .long_low(core_long)
  );

  logic          cnt_clr;
  logic [CW-1:0] cnt;

  prs_tick_cnt #(.MAXV(CNT_MAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick_ms), .cnt(cnt)
  );

  prs_state_e st_q, st_d;
  logic flag_set, flag_clr;
  logic ext_req, pwr_lost;

  assign ext_req  = ext_filt_d & ~ext_filt;
  assign pwr_lost = ~vrm_s | core_long;

  always_comb begin
    st_d     = st_q;
    cnt_clr  = 1'b0;
    flag_set = 1'b0;
    flag_clr = 1'b0;
    if (pwr_lost) begin
      st_d    = ST_PWR_WAIT;
      cnt_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_PWR_WAIT: begin
          cnt_clr = 1'b1;
          if (core_s && vrm_s) st_d = ST_HOLD;
        end
        ST_HOLD, ST_SW_PULSE, ST_EXT_PULSE: begin
          if (sw_hard_req)       cnt_clr = 1'b1;
          else if (cnt >= HOLD_C) st_d = ST_RUN;
        end
        ST_RUN: begin
          cnt_clr = 1'b1;
          if (sw_hard_req) begin
            st_d = ST_SW_PULSE;
          end else if (ext_req) begin
            if (mgmt_bus_idle) begin
              st_d     = ST_EXT_PULSE;
              flag_clr = 1'b1;
            end else begin
              st_d = ST_BUS_WAIT;
            end
          end
        end
        ST_BUS_WAIT: begin
          if (sw_hard_req) begin
            st_d    = ST_SW_PULSE;
            cnt_clr = 1'b1;
          end else if (mgmt_bus_idle) begin
            st_d     = ST_EXT_PULSE;
            cnt_clr  = 1'b1;
            flag_clr = 1'b1;
          end else if (cnt >= WAIT_C) begin
            st_d     = ST_EXT_PULSE;
            cnt_clr  = 1'b1;
            flag_set = 1'b1;
          end
        end
        default: begin
          st_d    = ST_PWR_WAIT;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_PWR_WAIT;
      ext_filt_d <= 1'b1;
      ext_forced <= 1'b0;
    end else begin
      st_q       <= st_d;
      ext_filt_d <= ext_filt;
      if (flag_set)      ext_forced <= 1'b1;
      else if (flag_clr) ext_forced <= 1'b0;
    end
  end

  assign plat_rst_n = core_s & ((st_q == ST_RUN) | (st_q == ST_BUS_WAIT));

  AST_VRM_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !vrm_s |=> !plat_rst_n); // R1
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(plat_rst_n) && ($past(st_q) != ST_RUN) && ($past(st_q) != ST_BUS_WAIT)
      |-> $past(cnt) >= HOLD_C); // R2
  AST_SW_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hard_req && !pwr_lost && (st_q == ST_RUN) |=> !plat_rst_n); // R3
  AST_LONG_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    core_long |=> (st_q == ST_PWR_WAIT)); // R6
  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUS_WAIT) |-> cnt <= WAIT_C); // R9
  AST_FLAG_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_forced) |-> ($past(st_q) == ST_BUS_WAIT) && !$past(mgmt_bus_idle)); // R10
endmodule

// File: tb/plat_rst_seq_tb_top.sv
module plat_rst_seq_tb_top;
  localparam int HOLD = 4;
  localparam int WAITT = 6;
  localparam int DEB = 3;
  localparam int FILT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic rtc_tick = 1'b0;
  logic core_pg_a = 1'b0;
  logic vrm_pg_a = 1'b0;
  logic sw_hard_req = 1'b0;
  logic ext_rst_req_n = 1'b1;
  logic mgmt_bus_idle = 1'b1;
  logic plat_rst_n, ext_forced;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  plat_rst_seq #(.HOLD_TICKS(HOLD), .WAIT_TICKS(WAITT), .DEB_TICKS(DEB), .RTC_FILT(FILT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .rtc_tick(rtc_tick),
    .core_pg_a(core_pg_a), .vrm_pg_a(vrm_pg_a), .sw_hard_req(sw_hard_req),
    .ext_rst_req_n(ext_rst_req_n), .mgmt_bus_idle(mgmt_bus_idle),
    .plat_rst_n(plat_rst_n), .ext_forced(ext_forced)
  );

  initial begin
    forever begin
      repeat (9) @(negedge clk);
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
    end
  end

  initial begin
    forever begin
      repeat (39) @(negedge clk);
      rtc_tick = 1'b1;
      @(negedge clk);
      rtc_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!tick_ms);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 in reset", plat_rst_n, 1'b0);
    chk("R10 flag reset", ext_forced, 1'b0);
    rst_n = 1'b1;
    wait_ticks(3);
    chk("R1 no power-good", plat_rst_n, 1'b0);
  endtask

  task automatic t_powerup();
    core_pg_a = 1'b1;
    wait_ticks(6);
    chk("R1 core only", plat_rst_n, 1'b0);
    vrm_pg_a = 1'b1;
    wait_ticks(HOLD - 1);
    chk("R2 still held", plat_rst_n, 1'b0);
    wait_ticks(2);
    chk("R2 released", plat_rst_n, 1'b1);
  endtask

  task automatic sw_pulse();
    @(negedge clk);
    sw_hard_req = 1'b1;
    @(negedge clk);
    sw_hard_req = 1'b0;
  endtask

  task automatic t_sw();
    sw_pulse();
    chk("R3 asserted next edge", plat_rst_n, 1'b0);
    wait_ticks(HOLD - 1);
    chk("R3 still held", plat_rst_n, 1'b0);
    wait_ticks(2);
    chk("R3 released", plat_rst_n, 1'b1);
  endtask

  task automatic t_sw_retrig();
    sw_pulse();
    wait_ticks(HOLD - 1);
    sw_pulse();
    wait_ticks(HOLD - 1);
    chk("R4 restarted hold", plat_rst_n, 1'b0);
    wait_ticks(2);
    chk("R4 released", plat_rst_n, 1'b1);
  endtask

  task automatic t_glitch();
    @(negedge clk);
    core_pg_a = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 immediate", plat_rst_n, 1'b0);
    repeat (48) @(negedge clk);
    core_pg_a = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 short dip filtered", plat_rst_n, 1'b1);
  endtask

  task automatic t_long();
    @(negedge clk);
    core_pg_a = 1'b0;
    repeat (200) @(negedge clk);
    core_pg_a = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 long dip holds", plat_rst_n, 1'b0);
    wait_ticks(HOLD + 1);
    chk("R6 released after hold", plat_rst_n, 1'b1);
  endtask

  task automatic t_ext_glitch();
    @(negedge clk);
    ext_rst_req_n = 1'b0;
    repeat (3) @(negedge clk);
    ext_rst_req_n = 1'b1;
    wait_ticks(DEB + 2);
    chk("R7 glitch ignored", plat_rst_n, 1'b1);
  endtask

  task automatic t_ext_idle();
    mgmt_bus_idle = 1'b1;
    @(negedge clk);
    ext_rst_req_n = 1'b0;
    wait_ticks(DEB - 1);
    chk("R7 not yet debounced", plat_rst_n, 1'b1);
    wait_ticks(2);
    chk("R8 pulse on idle bus", plat_rst_n, 1'b0);
    ext_rst_req_n = 1'b1;
    wait_ticks(HOLD + 1);
    chk("R8 released", plat_rst_n, 1'b1);
  endtask

  task automatic t_ext_busy();
    mgmt_bus_idle = 1'b0;
    @(negedge clk);
    ext_rst_req_n = 1'b0;
    wait_ticks(DEB + 1);
    chk("R9 waiting for bus", plat_rst_n, 1'b1);
    ext_rst_req_n = 1'b1;
    wait_ticks(WAITT - 2);
    chk("R9 still waiting", plat_rst_n, 1'b1);
    wait_ticks(4);
    chk("R9 forced after timeout", plat_rst_n, 1'b0);
    chk("R10 flag set", ext_forced, 1'b1);
    mgmt_bus_idle = 1'b1;
    wait_ticks(HOLD + 1);
    chk("R9 released", plat_rst_n, 1'b1);
  endtask

  task automatic t_ext_early_idle();
    mgmt_bus_idle = 1'b0;
    @(negedge clk);
    ext_rst_req_n = 1'b0;
    wait_ticks(DEB + 1);
    chk("R9 waiting again", plat_rst_n, 1'b1);
    ext_rst_req_n = 1'b1;
    wait_ticks(1);
    mgmt_bus_idle = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 pulse on idle", plat_rst_n, 1'b0);
    chk("R10 flag cleared", ext_forced, 1'b0);
    wait_ticks(HOLD + 1);
    chk("R9 released after idle", plat_rst_n, 1'b1);
  endtask

  task automatic t_vrm();
    @(negedge clk);
    vrm_pg_a = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 regulator drop", plat_rst_n, 1'b0);
    vrm_pg_a = 1'b1;
    wait_ticks(HOLD - 1);
    chk("R2 held after regulator", plat_rst_n, 1'b0);
    wait_ticks(2);
    chk("R2 released after regulator", plat_rst_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_sw();
    t_sw_retrig();
    t_glitch();
    t_long();
    t_ext_glitch();
    t_ext_idle();
    t_ext_busy();
    t_ext_early_idle();
    t_vrm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule